// File: doc/BRIEF.md
# Byte-to-Word IDE Data Bridge

This block joins a byte-wide host data bus to a word-wide IDE data bus. It holds two byte registers, one for each half of the IDE word. A host access moves a byte between the host and one of these registers. An access to the low byte also moves the whole word across the IDE bus. The host marks each access with a one-cycle strobe. It selects the low-byte path with one active-low select and the high-byte register with the other. A read/write line sets the direction: 1 means data flows from the IDE bus to the host, and 0 means data flows from the host to the IDE bus.

The order of accesses is fixed by the hardware. A low-byte read takes the full IDE word in a single edge, and a later high-byte read returns the stored half without touching the drive. On the write side, software first stores the high byte, then writes the low byte. That low-byte write launches the assembled word onto the IDE bus for one cycle. The block never reorders accesses. IDE strobe timing and address decoding are done outside this block.

Top module: `ide_width_bridge`

## Requirements
- R1: A synchronous reset (`rst` = 1 at a clock edge) clears both byte registers to zero and deasserts `ide_oe`.
- R2: A strobed low-byte read (`win_sel_n`=0, `hi_sel_n`=1, `host_rnw`=1) shows bits [7:0] of `ide_rdata` on `host_rdata` with `host_drv`=1 in the same cycle, and at the strobe edge loads bits [15:8] into the high-byte register and bits [7:0] into the low-byte register.
- R3: A high-byte read (`win_sel_n`=1, `hi_sel_n`=0, `host_rnw`=1) returns the stored high byte on `host_rdata` with `host_drv`=1, ignores `ide_rdata`, and leaves `ide_oe` at 0 in the next cycle.
- R4: A strobed high-byte write (`win_sel_n`=1, `hi_sel_n`=0, `host_rnw`=0) loads `host_wdata` into the high-byte register only, and `ide_oe` stays 0 in the following cycle.
- R5: A strobed low-byte write (`win_sel_n`=0, `hi_sel_n`=1, `host_rnw`=0) loads `host_wdata` into the low-byte register, and in the next cycle drives `ide_oe`=1 with `ide_wdata` = {high register, written byte} for exactly one cycle per strobe.
- R6: With both selects low (an illegal combination), a strobe changes neither register, `host_drv` is 0, and `ide_oe` is 0 in the next cycle.
- R7: With both selects high, the buses are isolated: `host_drv`=0, `host_rdata`=0, `ide_oe` is 0 in the next cycle, and a strobe changes no register.
- R8: Whenever `ide_oe` is 0, `ide_wdata` is all zeros.
- R9: Without `acc_stb`, no access changes either register, even while a select is active.
- R10: A strobed low-byte read after a high-byte write replaces the stored high byte with bits [15:8] of `ide_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_stb | input | 1 | One-cycle access strobe; registers update at the edge where it is high |
| host_rnw | input | 1 | 1 = IDE to host, 0 = host to IDE |
| win_sel_n | input | 1 | Low-byte path select, active low |
| hi_sel_n | input | 1 | High-byte register select, active low |
| host_wdata | input | HOST_W | Byte written by the host |
| host_rdata | output | HOST_W | Byte returned to the host |
| host_drv | output | 1 | Host read data valid / drive enable |
| ide_rdata | input | 2*HOST_W | Word read from the IDE bus |
| ide_wdata | output | 2*HOST_W | Word driven toward the IDE bus |
| ide_oe | output | 1 | IDE data output enable |

## Verification
The assertions assume that `acc_stb` comes with a stable decode of `host_rnw` and the two selects during the same cycle, and that reset is held high from the first edge. Strobed and unstrobed cycles are covered separately. The bench changes all inputs only on falling edges. It pulses `acc_stb` for single cycles or back to back. It applies the illegal select pair and the idle pair on purpose, so those checks see both of them under a strobe. Each read sets `ide_rdata` to a value that differs from the bytes held in the registers, so a byte taken from the wrong source shows up at the ports.

// File: rtl/ide_bridge_pkg.sv
`timescale 1ns/1ps
package ide_bridge_pkg;

   typedef enum logic [2:0] {
      ACC_IDLE  = 3'd0,
      ACC_BAD   = 3'd1,
      ACC_LO_RD = 3'd2,
      ACC_LO_WR = 3'd3,
      ACC_HI_RD = 3'd4,
      ACC_HI_WR = 3'd5
   } acc_e;

   // Classify one host cycle from direction and the two active-low selects.
   function automatic acc_e classify(input logic rnw, input logic win_n, input logic hi_n);
      acc_e k;
      case ({win_n, hi_n})
         2'b11:   k = ACC_IDLE;
         2'b00:   k = ACC_BAD;
         2'b01:   k = rnw ? ACC_LO_RD : ACC_LO_WR;
         default: k = rnw ? ACC_HI_RD : ACC_HI_WR;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/ide_bridge_decode.sv
`timescale 1ns/1ps
module ide_bridge_decode
   import ide_bridge_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic acc_stb,
   input  logic host_rnw,
   input  logic win_sel_n,
   input  logic hi_sel_n,
   output acc_e kind,
   output logic lo_ld_ide,
   output logic lo_ld_host,
   output logic hi_ld_ide,
   output logic hi_ld_host,
   output logic push_word
);

   always_comb begin
      kind       = classify(host_rnw, win_sel_n, hi_sel_n);
      lo_ld_ide  = acc_stb && (kind == ACC_LO_RD);
      hi_ld_ide  = acc_stb && (kind == ACC_LO_RD);
      lo_ld_host = acc_stb && (kind == ACC_LO_WR);
      hi_ld_host = acc_stb && (kind == ACC_HI_WR);
      push_word  = acc_stb && (kind == ACC_LO_WR);
   end

   // R4
   hi_write_excl_chk: assert property (@(posedge clk) disable iff (rst)
      hi_ld_host |-> !(lo_ld_host || lo_ld_ide || hi_ld_ide));

   // R6
   bad_no_load_chk: assert property (@(posedge clk) disable iff (rst)
      (!win_sel_n && !hi_sel_n) |-> !(lo_ld_ide || lo_ld_host || hi_ld_ide || hi_ld_host));

endmodule

// File: rtl/ide_bridge_hold.sv
`timescale 1ns/1ps
module ide_bridge_hold #(
   parameter int            W         = 8,
   parameter logic [W-1:0]  RST_VAL   = '0,
   parameter bit            HOST_WINS = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld_ide,
   input  logic [W-1:0] ide_d,
   input  logic         ld_host,
   input  logic [W-1:0] host_d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("ide_bridge_hold: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] nxt;
   logic         ld_any;

   assign ld_any = ld_ide || ld_host;

   generate
      if (HOST_WINS) begin : g_host_first
         always_comb nxt = ld_host ? host_d : ide_d;
      end else begin : g_ide_first
         always_comb nxt = ld_ide ? ide_d : host_d;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)         q <= RST_VAL;
      else if (ld_any) q <= nxt;
   end

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !ld_ide && !ld_host |=> $stable(q));

   // R2
   ide_capture_chk: assert property (@(posedge clk) disable iff (rst)
      ld_ide && !ld_host |=> q == $past(ide_d));

endmodule

// File: rtl/ide_bridge_route.sv
`timescale 1ns/1ps
module ide_bridge_route
   import ide_bridge_pkg::*;
#(
   parameter int HW = 8,
   localparam int IW = 2 * HW
) (
   input  logic          clk,
   input  logic          rst,
   input  acc_e          kind,
   input  logic          push_word,
   input  logic [HW-1:0] ide_lo,
   input  logic [HW-1:0] hi_q,
   input  logic [HW-1:0] lo_q,
   output logic [HW-1:0] host_rdata,
   output logic          host_drv,
   output logic          ide_oe,
   output logic [IW-1:0] ide_wdata
);

   always_comb begin
      host_drv   = 1'b0;
      host_rdata = '0;
      case (kind)
         ACC_LO_RD: begin host_drv = 1'b1; host_rdata = ide_lo; end
         ACC_HI_RD: begin host_drv = 1'b1; host_rdata = hi_q;   end
         default:   ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) ide_oe <= 1'b0;
      else     ide_oe <= push_word;
   end

   assign ide_wdata = ide_oe ? {hi_q, lo_q} : '0;

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (kind == ACC_IDLE) |-> (host_rdata == '0));

endmodule

// File: rtl/ide_width_bridge.sv
`timescale 1ns/1ps
module ide_width_bridge
   import ide_bridge_pkg::*;
#(
   parameter int HOST_W = 8,
   localparam int IDE_W = 2 * HOST_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_stb,
   input  logic              host_rnw,
   input  logic              win_sel_n,
   input  logic              hi_sel_n,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   output logic              host_drv,
   input  logic [IDE_W-1:0]  ide_rdata,
   output logic [IDE_W-1:0]  ide_wdata,
   output logic              ide_oe
);

   generate
      if (HOST_W < 1) begin : g_bad_width
         $error("ide_width_bridge: HOST_W must be at least 1");
      end
   endgenerate

   acc_e              kind;
   logic              lo_ld_ide, lo_ld_host, hi_ld_ide, hi_ld_host, push_word;
   logic [HOST_W-1:0] lo_q, hi_q;

   ide_bridge_decode u_dec (
      .clk        (clk),
      .rst        (rst),
      .acc_stb    (acc_stb),
      .host_rnw   (host_rnw),
      .win_sel_n  (win_sel_n),
      .hi_sel_n   (hi_sel_n),
      .kind       (kind),
      .lo_ld_ide  (lo_ld_ide),
      .lo_ld_host (lo_ld_host),
      .hi_ld_ide  (hi_ld_ide),
      .hi_ld_host (hi_ld_host),
      .push_word  (push_word)
   );

   ide_bridge_hold #(.W(HOST_W)) u_lo (
      .clk     (clk),
      .rst     (rst),
      .ld_ide  (lo_ld_ide),
      .ide_d   (ide_rdata[HOST_W-1:0]),
      .ld_host (lo_ld_host),
      .host_d  (host_wdata),
      .q       (lo_q)
   );

   ide_bridge_hold #(.W(HOST_W)) u_hi (
      .clk     (clk),
      .rst     (rst),
      .ld_ide  (hi_ld_ide),
      .ide_d   (ide_rdata[IDE_W-1:HOST_W]),
      .ld_host (hi_ld_host),
      .host_d  (host_wdata),
      .q       (hi_q)
   );

   ide_bridge_route #(.HW(HOST_W)) u_route (
      .clk        (clk),
      .rst        (rst),
      .kind       (kind),
      .push_word  (push_word),
      .ide_lo     (ide_rdata[HOST_W-1:0]),
      .hi_q       (hi_q),
      .lo_q       (lo_q),
      .host_rdata (host_rdata),
      .host_drv   (host_drv),
      .ide_oe     (ide_oe),
      .ide_wdata  (ide_wdata)
   );

   // R5
   lo_write_push_chk: assert property (@(posedge clk) disable iff (rst)
      acc_stb && !win_sel_n && hi_sel_n && !host_rnw |=>
         ide_oe && (ide_wdata[HOST_W-1:0] == $past(host_wdata)));

   // R3
   hi_read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
      acc_stb && win_sel_n && !hi_sel_n && host_rnw |=> !ide_oe && $stable(hi_q));

   // R6
   bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !win_sel_n && !hi_sel_n |=> !ide_oe && $stable(hi_q) && $stable(lo_q));

   // R2
   lo_read_word_chk: assert property (@(posedge clk) disable iff (rst)
      acc_stb && !win_sel_n && hi_sel_n && host_rnw |=>
         hi_q == $past(ide_rdata[IDE_W-1:HOST_W]));

   // R8
   wdata_released_chk: assert property (@(posedge clk) disable iff (rst)
      !ide_oe |-> ide_wdata == '0);

   // R7
   idle_no_drv_chk: assert property (@(posedge clk) disable iff (rst)
      win_sel_n && hi_sel_n |-> !host_drv);

endmodule

// File: tb/ide_width_bridge_bench.sv
`timescale 1ns/1ps
module ide_width_bridge_bench;

   typedef struct {
      int          cyc;
      string       tag;
      logic [7:0]  rd;
      logic        drv;
      logic        oe;
      logic [15:0] wd;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        acc_stb = 1'b0;
   logic        host_rnw = 1'b1;
   logic        win_sel_n = 1'b1;
   logic        hi_sel_n = 1'b1;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_drv;
   logic [15:0] ide_rdata = '0;
   logic [15:0] ide_wdata;
   logic        ide_oe;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 1'b0;
   exp_t sb[$];

   logic [7:0] m_hi = '0, m_lo = '0;
   logic       m_oe = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ide_width_bridge u_ide_width_bridge (
      .clk(clk), .rst(rst), .acc_stb(acc_stb), .host_rnw(host_rnw),
      .win_sel_n(win_sel_n), .hi_sel_n(hi_sel_n), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_drv(host_drv), .ide_rdata(ide_rdata),
      .ide_wdata(ide_wdata), .ide_oe(ide_oe)
   );

   // Driver: apply one cycle at the falling edge, push what the ports must show.
   task automatic step(input string tag, input bit rnw, input bit wn, input bit hn,
                       input bit stb, input logic [7:0] hd, input logic [15:0] id);
      exp_t e;
      @(negedge clk);
      host_rnw = rnw; win_sel_n = wn; hi_sel_n = hn; acc_stb = stb;
      host_wdata = hd; ide_rdata = id;
      e.cyc = cyc; e.tag = tag; e.oe = m_oe;
      e.wd  = m_oe ? {m_hi, m_lo} : 16'h0;
      e.drv = rnw && (wn != hn);
      e.rd  = !e.drv ? 8'h0 : (!wn ? id[7:0] : m_hi);
      sb.push_back(e);
      m_oe = stb && !wn && hn && !rnw;
      if (stb && (wn != hn)) begin
         if (!wn && rnw)      begin m_lo = id[7:0]; m_hi = id[15:8]; end
         else if (!wn)        m_lo = hd;
         else if (!rnw)       m_hi = hd;
      end
   endtask

   task automatic idle(input string tag);
      step(tag, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 16'h0000);
   endtask

   // Monitor: pop and compare items that belong to this cycle.
   always @(negedge clk) begin
      #2;
      while (sb.size() > 0 && sb[0].cyc == cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (host_rdata !== e.rd || host_drv !== e.drv || ide_oe !== e.oe || ide_wdata !== e.wd) begin
            failures++;
            $display("FAIL %s: rd=%h drv=%b oe=%b wd=%h expected rd=%h drv=%b oe=%b wd=%h",
                     e.tag, host_rdata, host_drv, ide_oe, ide_wdata, e.rd, e.drv, e.oe, e.wd);
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      @(negedge clk); rst = 1'b0;
      idle("R1 reset idle");
      idle("R7 isolation idle");
      step("R1 high byte cleared", 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 16'hFFFF);
      step("R1 low write after reset", 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 16'h0000);
      idle("R5 word with cleared high");
      idle("R8 released after push");
      step("R2 low read", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 16'hBEEF);
      step("R3 high read ignores bus", 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 16'h1234);
      idle("R3 no drive after high read");
      step("R4 high write", 1'b0, 1'b1, 1'b0, 1'b1, 8'h77, 16'h0000);
      idle("R4 no drive after high write");
      step("R4 high read back", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000);
      step("R5 low write a", 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 16'h0000);
      step("R5 low write b", 1'b0, 1'b0, 1'b1, 1'b1, 8'h22, 16'h0000);
      idle("R5 second word");
      idle("R8 released");
      step("R6 illegal write", 1'b0, 1'b0, 1'b0, 1'b1, 8'h99, 16'h0000);
      step("R6 illegal read", 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 16'hCDAB);
      idle("R6 no drive");
      step("R6 high kept", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000);
      step("R7 idle strobe", 1'b0, 1'b1, 1'b1, 1'b1, 8'h66, 16'h0000);
      idle("R7 no drive");
      step("R7 high kept", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000);
      step("R9 high write no strobe", 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 16'h0000);
      step("R9 low read no strobe", 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 16'h4455);
      step("R9 high kept", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000);
      step("R10 high write", 1'b0, 1'b1, 1'b0, 1'b1, 8'h88, 16'h0000);
      step("R10 low read", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 16'hA1B2);
      step("R10 high replaced", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000);
      step("R5 push after read", 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, 16'h0000);
      idle("R5 word after read");
      idle("R8 final release");
      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         failures++;
         checks++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule